// File: doc/BRIEF.md
# MAC Interrupt Status and Enable Unit

This unit collects single-cycle event pulses from the transmit and receive DMA engines of an Ethernet MAC. It holds them in a 32-bit sticky status word. A 32-bit enable word gates the status word, and the result drives two interrupt lines. The upper half of the status word carries transmit events and drives the transmit interrupt. The lower half carries receive events and drives the receive interrupt.

Software reaches both words through a one-bit register select, a write strobe and a combinational read port. It writes the enable word directly. It clears status bits by writing ones to them. A synchronous software reset input clears both words at once, as does the asynchronous active-low reset.

The implemented status positions are:

| Bit | Event |
|---|---|
| 0 | receive interrupt |
| 3 | oversize frame |
| 4 | good frame received |
| 8 | frame length limit |
| 9 | early DMA notice |
| 10 | receive descriptor missing |
| 11 | receive bus fault |
| 16 | transmit interrupt |
| 18 | transmit done |
| 23 | transmit descriptor missing |
| 24 | transmit bus fault |

The implemented enable positions are 0, 4, 16 and 18.

Top module: `mac_irq_hub`

## Requirements
- R1: After the asynchronous reset, the status word (reg_sel=0) and the enable word (reg_sel=1) both read 0, and both interrupt outputs are low.
- R2: An event pulse on an implemented status position (bits 0, 3, 4, 8, 9, 10, 11, 16, 18, 23, 24) sets that status bit at the next clock edge. The bit stays set until it is cleared.
- R3: A status bit latches even while its enable bit is 0. In that case neither interrupt output rises.
- R4: A write with reg_sel=0 clears every status bit whose write-data bit is 1 and leaves the others unchanged. For example, writing 0xFFFF0000 clears only the transmit half, and writing 0 changes nothing.
- R5: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: A write with reg_sel=1 loads the enable word. Only bits 0, 4, 16 and 18 are stored, and every other enable bit reads 0.
- R7: irq_tx is the OR of status AND enable over bits 31:16. irq_rx is the same OR over bits 15:0. Both follow the registers in the same cycle they change.
- R8: Status positions outside the implemented set never become 1, whatever the event input.
- R9: sw_rst high at a clock edge clears both words. It takes priority over events and writes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset of both words |
| evt_pulse | input | 32 | One pulse line per status position |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the enable word |
| reg_wdata | input | 32 | Write data (ones clear status bits) |
| reg_rdata | output | 32 | Read data of the selected word |
| irq_tx | output | 1 | Transmit interrupt (bits 31:16) |
| irq_rx | output | 1 | Receive interrupt (bits 15:0) |

## Verification
The hardest case to reach from the ports is a clearing write that lands on a bit in the same edge as a fresh event for that bit. The other hard case is a software reset that coincides with both events and a write. The bench builds both cases by holding a pulse, a write strobe and sw_rst together for one negedge-to-negedge window. Around that, it sweeps every one of the 32 event positions with enables off. It also sweeps all 16 enable combinations against full, transmit-only and receive-only status patterns. All expectations come from a running arithmetic model of the two words.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int unsigned DW = 32;

  // Status positions (transmit half 31:16, receive half 15:0)
  localparam int unsigned B_RX_IRQ     = 0;
  localparam int unsigned B_RX_LONG    = 3;
  localparam int unsigned B_RX_GOOD    = 4;
  localparam int unsigned B_RX_MAXLEN  = 8;
  localparam int unsigned B_RX_EARLY   = 9;
  localparam int unsigned B_RX_NODESC  = 10;
  localparam int unsigned B_RX_BUSERR  = 11;
  localparam int unsigned B_TX_IRQ     = 16;
  localparam int unsigned B_TX_DONE    = 18;
  localparam int unsigned B_TX_NODESC  = 23;
  localparam int unsigned B_TX_BUSERR  = 24;

  localparam logic [DW-1:0] STS_MASK_DEF =
      (DW'(1) << B_RX_IRQ)    | (DW'(1) << B_RX_LONG)   |
      (DW'(1) << B_RX_GOOD)   | (DW'(1) << B_RX_MAXLEN) |
      (DW'(1) << B_RX_EARLY)  | (DW'(1) << B_RX_NODESC) |
      (DW'(1) << B_RX_BUSERR) | (DW'(1) << B_TX_IRQ)    |
      (DW'(1) << B_TX_DONE)   | (DW'(1) << B_TX_NODESC) |
      (DW'(1) << B_TX_BUSERR);

  localparam logic [DW-1:0] EN_MASK_DEF =
      (DW'(1) << B_RX_IRQ) | (DW'(1) << B_RX_GOOD) |
      (DW'(1) << B_TX_IRQ) | (DW'(1) << B_TX_DONE);

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;

  // Next value of one sticky bit: a set beats a clear.
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return (cur & ~clr) | set;
  endfunction

  // Any enabled-and-pending bit in a slice.
  function automatic logic any_pending(logic [DW/2-1:0] sts, logic [DW/2-1:0] en);
    return |(sts & en);
  endfunction
endpackage

// File: rtl/mac_irq_status.sv
module mac_irq_status #(
  parameter int unsigned   W    = 32,
  parameter logic [W-1:0]  IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] sts_q
);
  import mac_irq_pkg::*;

  // Named internal events for the assertions
  logic [W-1:0] set_hit;
  logic [W-1:0] clr_hit;
  logic [W-1:0] collide;

  assign set_hit = evt & IMPL;
  assign clr_hit = clr & IMPL & ~set_hit;
  assign collide = evt & clr & IMPL;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_on
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sts_q[b] <= 1'b0;
        else if (sw_rst) sts_q[b] <= 1'b0;
        else             sts_q[b] <= sticky_next(sts_q[b], set_hit[b], clr[b]);
      end
    end else begin : g_off
      assign sts_q[b] = 1'b0;
    end
  end

  AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && |set_hit) |=> ((sts_q & $past(set_hit)) == $past(set_hit))); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && |clr_hit) |=> ((sts_q & $past(clr_hit)) == '0)); // R4
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && |collide) |=> ((sts_q & $past(collide)) == $past(collide))); // R5
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && evt == '0 && clr == '0) |=> $stable(sts_q)); // R4
  AST_NO_GHOST_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~IMPL) == '0); // R8
  AST_SWRST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (sts_q == '0)); // R9
endmodule

// File: rtl/mac_irq_enable.sv
module mac_irq_enable #(
  parameter int unsigned   W    = 32,
  parameter logic [W-1:0]  IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_on
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q[b] <= 1'b0;
        else if (sw_rst) en_q[b] <= 1'b0;
        else if (wr)     en_q[b] <= wdata[b];
      end
    end else begin : g_off
      assign en_q[b] = 1'b0;
    end
  end

  AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sw_rst) |=> (en_q == ($past(wdata) & IMPL))); // R6
  AST_EN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !sw_rst) |=> $stable(en_q)); // R6
  AST_SWRST_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (en_q == '0)); // R9
endmodule

// File: rtl/mac_irq_merge.sv
module mac_irq_merge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sts,
  input  logic [W-1:0] en,
  output logic         irq_hi,
  output logic         irq_lo
);
  import mac_irq_pkg::*;
  localparam int unsigned H = W / 2;

  assign irq_hi = any_pending(sts[W-1:H], en[W-1:H]);
  assign irq_lo = any_pending(sts[H-1:0], en[H-1:0]);

  AST_HI_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (|sts[W-1:H] && |en[W-1:H])); // R7
  AST_LO_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (|sts[H-1:0] && |en[H-1:0])); // R7
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (!irq_hi && !irq_lo)); // R3
endmodule

// File: rtl/mac_irq_hub.sv
module mac_irq_hub #(
  parameter int unsigned                   DW       = mac_irq_pkg::DW,
  parameter logic [mac_irq_pkg::DW-1:0]    STS_IMPL = mac_irq_pkg::STS_MASK_DEF,
  parameter logic [mac_irq_pkg::DW-1:0]    EN_IMPL  = mac_irq_pkg::EN_MASK_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic [DW-1:0] evt_pulse,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_tx,
  output logic          irq_rx
);
  import mac_irq_pkg::*;

  logic          wr_status;
  logic          wr_enable;
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] sts_q;
  logic [DW-1:0] en_q;

  assign wr_status = reg_wr && (reg_sel == SEL_STATUS);
  assign wr_enable = reg_wr && (reg_sel == SEL_ENABLE);
  assign clr_vec   = wr_status ? reg_wdata : '0;

  mac_irq_status #(.W(DW), .IMPL(STS_IMPL)) u_status (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .evt(evt_pulse), .clr(clr_vec), .sts_q(sts_q)
  );

  mac_irq_enable #(.W(DW), .IMPL(EN_IMPL)) u_enable (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .wr(wr_enable), .wdata(reg_wdata), .en_q(en_q)
  );

  mac_irq_merge #(.W(DW)) u_merge (
    .clk(clk), .rst_n(rst_n), .sts(sts_q), .en(en_q),
    .irq_hi(irq_tx), .irq_lo(irq_rx)
  );

  assign reg_rdata = (reg_sel == SEL_ENABLE) ? en_q : sts_q;

  AST_ENABLE_WRITE_SPARES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && !sw_rst && evt_pulse == '0) |=> $stable(sts_q)); // R4
  AST_STATUS_WRITE_SPARES_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !sw_rst) |=> $stable(en_q)); // R6
endmodule

// File: tb/mac_irq_hub_test.sv
module mac_irq_hub_test;
  localparam logic [31:0] SM = 32'h0185_0F19;
  localparam logic [31:0] EM = 32'h0005_0011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic [31:0] evt_pulse = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_tx, irq_rx;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] sts_m = '0;
  logic [31:0] en_m = '0;

  always #2 clk = ~clk;

  mac_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .evt_pulse(evt_pulse),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock with the given stimulus; updates the model from the requirements.
  task automatic cyc(logic [31:0] ev, logic wr, logic sel, logic [31:0] d, logic swr);
    @(negedge clk);
    evt_pulse = ev; reg_wr = wr; reg_sel = sel; reg_wdata = d; sw_rst = swr;
    @(posedge clk);
    #1;
    evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0; sw_rst = 1'b0;
    if (swr) begin
      sts_m = '0; en_m = '0;
    end else begin
      if (wr && !sel) sts_m = sts_m & ~d;
      sts_m = sts_m | (ev & SM);
      if (wr && sel) en_m = d & EM;
    end
  endtask

  task automatic check_all(string req);
    logic [31:0] p;
    reg_sel = 1'b0; #1;
    chk(req, reg_rdata, sts_m);
    reg_sel = 1'b1; #1;
    chk(req, reg_rdata, en_m);
    p = sts_m & en_m;
    chk({req, " irq"}, {30'd0, irq_tx, irq_rx}, {30'd0, |p[31:16], |p[15:0]});
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check_all("R1");
    rst_n = 1'b1;
    #1 check_all("R1");

    // R6: only the four enable positions store
    cyc('0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    check_all("R6");
    cyc('0, 1'b1, 1'b1, 32'h0, 1'b0);
    check_all("R6");

    // R2 / R3 / R8: every event position with enables off, then W1C
    for (int i = 0; i < 32; i++) begin
      cyc(32'h1 << i, 1'b0, 1'b0, '0, 1'b0);
      check_all(SM[i] ? "R2_R3" : "R8");
      cyc('0, 1'b0, 1'b0, '0, 1'b0);
      check_all("R2");
      cyc('0, 1'b1, 1'b0, 32'h1 << i, 1'b0);
      check_all("R4");
    end

    // R4: half clear and zero write
    cyc(32'hFFFF_FFFF, 1'b0, 1'b0, '0, 1'b0);
    check_all("R8");
    cyc('0, 1'b1, 1'b0, 32'h0, 1'b0);
    check_all("R4");
    cyc('0, 1'b1, 1'b0, 32'hFFFF_0000, 1'b0);
    check_all("R4");
    chk("R4 rx kept", sts_m, SM & 32'h0000_FFFF);

    // R7: all enable combinations against three status patterns
    for (int s = 0; s < 3; s++) begin
      logic [31:0] pat;
      pat = (s == 0) ? SM : (s == 1) ? (SM & 32'hFFFF) : (SM & 32'hFFFF_0000);
      cyc('0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
      cyc(pat, 1'b0, 1'b0, '0, 1'b0);
      for (int e = 0; e < 16; e++) begin
        logic [31:0] ew;
        ew = {13'd0, e[3], 1'b0, e[2], 11'd0, e[1], 3'd0, e[0]};
        cyc('0, 1'b1, 1'b1, ew, 1'b0);
        check_all("R7");
      end
    end

    // R5: event and clear collide on bit 18 and bit 4
    cyc('0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
    cyc(32'h0004_0010, 1'b1, 1'b0, 32'h0004_0019, 1'b0);
    check_all("R5");
    chk("R5 bits", sts_m & 32'h0004_0019, 32'h0004_0010);

    // R9: sw_rst beats events and writes
    cyc(SM, 1'b0, 1'b0, '0, 1'b0);
    cyc('0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    check_all("R9");
    cyc(SM, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1);
    check_all("R9");
    chk("R9 cleared", sts_m | en_m, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule